// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block holds two independent breakpoint pairs. Each pair has a 32-bit data pattern and a 32-bit mask. On every valid data access the block compares the bus data with each pattern. Bit positions that the mask excludes are ignored. When a pair is enabled by the external trigger-definition control and every bit that counts agrees, the block raises that pair's match flag on the next clock.

Software reaches the registers through a small debug register port. The port has a 5-bit register index, read and write strobes, 32-bit write data, registered read data and an error strobe. Pattern registers can be written and read back. Mask registers can only be written. Register contents are not initialised by reset, so software loads every register before it sets a trigger enable.

Top module: `dbw_data_watch`

## Requirements
- R1: The pattern of pair 0 is at index 0x0E and the pattern of pair 1 is at index 0x1E. A write to either index stores reg_wdata. A read of either index returns the stored value on reg_rdata in the cycle after reg_rd, with reg_err low.
- R2: The masks of pair 0 and pair 1 sit at indices 0x0F and 0x1F and accept writes only. In the cycle after a read of either index, reg_rdata is zero and reg_err is high.
- R3: A read of any index other than 0x0E, 0x0F, 0x1E or 0x1F returns zero on reg_rdata and raises reg_err in the following cycle.
- R4: reg_err is high only in the cycle directly after a failing read. It is low after any cycle without reg_rd.
- R5: hit[n] is registered. It is high in the cycle after a cycle in which trig_en[n] and acc_valid are high and acc_data equals pattern n on every unmasked bit.
- R6: A mask bit of 1 removes that bit position from the comparison, and a mask bit of 0 requires the bit to be equal. An all-ones mask matches any data, and an all-zero mask requires the whole word to be equal.
- R7: When trig_en[n] is low, hit[n] is low in the following cycle, whatever the data.
- R8: When acc_valid is low, both hit bits are low in the following cycle.
- R9: The pairs are independent. Writing one pair's registers does not change the other pair, and each hit bit uses only its own pair's registers and enable.
- R10: Reset clears hit, reg_err and reg_rdata to zero. Reset leaves the pattern and mask contents unchanged.
- R11: When a read and a write of the same pattern index happen in the same cycle, the read returns the previous contents, and the new value is seen by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 5 | Debug register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_err | output | 1 | Failed-read strobe, registered |
| acc_valid | input | 1 | Data access valid this cycle |
| acc_data | input | 32 | Data value of the access |
| trig_en | input | 2 | Per-pair trigger enable |
| hit | output | 2 | Per-pair match flag, registered |

## Verification
Every result of this block is due exactly one clock after its stimulus. Read data and the error strobe follow the read strobe by one cycle, and each match flag follows its qualifying access by one cycle. The bench drives inputs on the falling edge, holds them across one rising edge, removes them, and samples on the next falling edge, so each result is checked in the single cycle in which it is valid. The error strobe is checked again one cycle later to confirm that it lasts only that cycle.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

   localparam int unsigned PAIR_STRIDE = 16;
   localparam int unsigned PAT_OFFSET  = 14;
   localparam int unsigned MSK_OFFSET  = 15;

   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_PAT  = 2'd1,
      SLOT_MSK  = 2'd2
   } slot_kind_e;

   function automatic int unsigned pat_slot(input int unsigned n);
      return PAT_OFFSET + PAIR_STRIDE * n;
   endfunction

   function automatic int unsigned msk_slot(input int unsigned n);
      return MSK_OFFSET + PAIR_STRIDE * n;
   endfunction

endpackage

// File: rtl/dbw_decode.sv
module dbw_decode
   import dbw_pkg::*;
#(
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned NUM_PAIRS = 2
) (
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_PAIRS-1:0] pat_sel,
   output logic [NUM_PAIRS-1:0] msk_sel,
   output slot_kind_e           kind
);

   for (genvar n = 0; n < NUM_PAIRS; n++) begin : g_slot
      localparam logic [IDX_W-1:0] PAT_IDX = IDX_W'(pat_slot(n));
      localparam logic [IDX_W-1:0] MSK_IDX = IDX_W'(msk_slot(n));
      assign pat_sel[n] = (idx == PAT_IDX);
      assign msk_sel[n] = (idx == MSK_IDX);
   end

   always_comb begin
      if (|pat_sel)      kind = SLOT_PAT;
      else if (|msk_sel) kind = SLOT_MSK;
      else               kind = SLOT_NONE;
   end

endmodule

// File: rtl/dbw_regbank.sv
module dbw_regbank
   import dbw_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_PAIRS = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic                              rd,
   input  logic [DATA_W-1:0]                 wdata,
   input  logic [NUM_PAIRS-1:0]              pat_sel,
   input  logic [NUM_PAIRS-1:0]              msk_sel,
   input  slot_kind_e                        kind,
   output logic [DATA_W-1:0]                 rdata,
   output logic                              err,
   output logic [NUM_PAIRS-1:0][DATA_W-1:0]  pat_o,
   output logic [NUM_PAIRS-1:0][DATA_W-1:0]  msk_o
);

   logic [NUM_PAIRS-1:0][DATA_W-1:0] pat_q;
   logic [NUM_PAIRS-1:0][DATA_W-1:0] msk_q;
   logic [DATA_W-1:0]                rd_val;
   logic                             rd_ok;

   // storage is deliberately left without reset
   for (genvar n = 0; n < NUM_PAIRS; n++) begin : g_store
      always_ff @(posedge clk) begin
         if (wr && pat_sel[n]) pat_q[n] <= wdata;
         if (wr && msk_sel[n]) msk_q[n] <= wdata;
      end

      // R1
      pat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && pat_sel[n]) |=> (pat_q[n] == $past(wdata)))
         else $error("pattern store lost a write");
   end

   always_comb begin
      rd_val = '0;
      for (int n = 0; n < NUM_PAIRS; n++) begin
         if (pat_sel[n]) rd_val = rd_val | pat_q[n];
      end
   end

   assign rd_ok = (kind == SLOT_PAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= rd && !rd_ok;
         if (rd) rdata <= rd_ok ? rd_val : '0;
      end
   end

   assign pat_o = pat_q;
   assign msk_o = msk_q;

   // R4
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !err)
      else $error("error strobe without a read");

   // R2 R3
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0))
      else $error("failed read returned data");

endmodule

// File: rtl/dbw_match.sv
module dbw_match #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              valid,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] pat,
   input  logic [DATA_W-1:0] msk,
   output logic              hit
);

   logic [DATA_W-1:0] diff;
   logic              eq;

   assign diff = (data ^ pat) & ~msk;
   assign eq   = (diff == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= en && valid && eq;
   end

   // R7
   hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !hit)
      else $error("match flag raised while disabled");

   // R8
   hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> !hit)
      else $error("match flag raised without an access");

   // R6
   full_mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && valid && (&msk)) |=> hit)
      else $error("fully masked compare did not match");

endmodule

// File: rtl/dbw_data_watch.sv
module dbw_data_watch
   import dbw_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned NUM_PAIRS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     reg_idx,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 reg_err,
   input  logic                 acc_valid,
   input  logic [DATA_W-1:0]    acc_data,
   input  logic [NUM_PAIRS-1:0] trig_en,
   output logic [NUM_PAIRS-1:0] hit
);

   localparam int unsigned TOP_SLOT = msk_slot(NUM_PAIRS - 1);

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("NUM_PAIRS must be at least 1");
   end
   if (TOP_SLOT >= (1 << IDX_W)) begin : g_bad_index
      $error("register slots do not fit the index width");
   end

   logic [NUM_PAIRS-1:0]             pat_sel;
   logic [NUM_PAIRS-1:0]             msk_sel;
   slot_kind_e                       kind;
   logic [NUM_PAIRS-1:0][DATA_W-1:0] pat_w;
   logic [NUM_PAIRS-1:0][DATA_W-1:0] msk_w;

   dbw_decode #(
      .IDX_W     (IDX_W),
      .NUM_PAIRS (NUM_PAIRS)
   ) u_decode (
      .idx     (reg_idx),
      .pat_sel (pat_sel),
      .msk_sel (msk_sel),
      .kind    (kind)
   );

   dbw_regbank #(
      .DATA_W    (DATA_W),
      .NUM_PAIRS (NUM_PAIRS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .rd      (reg_rd),
      .wdata   (reg_wdata),
      .pat_sel (pat_sel),
      .msk_sel (msk_sel),
      .kind    (kind),
      .rdata   (reg_rdata),
      .err     (reg_err),
      .pat_o   (pat_w),
      .msk_o   (msk_w)
   );

   for (genvar n = 0; n < NUM_PAIRS; n++) begin : g_pair
      dbw_match #(
         .DATA_W (DATA_W)
      ) u_match (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (trig_en[n]),
         .valid (acc_valid),
         .data  (acc_data),
         .pat   (pat_w[n]),
         .msk   (msk_w[n]),
         .hit   (hit[n])
      );
   end

endmodule

// File: tb/dbw_data_watch_tb.sv
`timescale 1ns/1ps
module dbw_data_watch_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_idx = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_err;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_data = '0;
   logic [1:0]  trig_en = '0;
   logic [1:0]  hit;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dbw_data_watch dut_i (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_err(reg_err), .acc_valid(acc_valid), .acc_data(acc_data),
      .trig_en(trig_en), .hit(hit)
   );

   typedef struct packed {
      logic        pair;
      logic [31:0] pat;
      logic [31:0] msk;
      logic [31:0] data;
      logic        valid;
      logic        en;
      logic        exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF, 1'b1, 1'b1, 1'b1},
      '{1'b0, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEE, 1'b1, 1'b1, 1'b0},
      '{1'b1, 32'h12345678, 32'h0000FFFF, 32'h1234ABCD, 1'b1, 1'b1, 1'b1},
      '{1'b1, 32'h12345678, 32'h0000FFFF, 32'h1235ABCD, 1'b1, 1'b1, 1'b0},
      '{1'b0, 32'h00000000, 32'hFFFFFFFF, 32'hA5A5A5A5, 1'b1, 1'b1, 1'b1},
      '{1'b1, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1},
      '{1'b1, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0},
      '{1'b0, 32'hCAFEF00D, 32'h00000000, 32'hCAFEF00D, 1'b1, 1'b0, 1'b0},
      '{1'b0, 32'hCAFEF00D, 32'h00000000, 32'hCAFEF00D, 1'b0, 1'b1, 1'b0}
   };

   function automatic logic [4:0] pat_at(input int p);
      return 5'(14 + 16 * p);
   endfunction
   function automatic logic [4:0] msk_at(input int p);
      return 5'(15 + 16 * p);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] idx, input logic [31:0] d);
      reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] idx, output logic [31:0] d, output logic e);
      reg_idx = idx; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata; e = reg_err;
   endtask

   task automatic access(input logic [1:0] en, input logic v, input logic [31:0] d);
      trig_en = en; acc_valid = v; acc_data = d;
      @(negedge clk);
      trig_en = '0; acc_valid = 1'b0; acc_data = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic e;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(hit == 2'b00, "R10 hit at reset", 32'(hit), 32'h0);
      chk(reg_err == 1'b0, "R10 err at reset", 32'(reg_err), 32'h0);
      chk(reg_rdata == '0, "R10 rdata at reset", reg_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // load every register before any enable
      for (int p = 0; p < 2; p++) begin
         wr(pat_at(p), 32'h0);
         wr(msk_at(p), 32'hFFFFFFFF);
      end

      // vector table: R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         wr(pat_at(int'(VECS[i].pair)), VECS[i].pat);
         wr(msk_at(int'(VECS[i].pair)), VECS[i].msk);
         access(VECS[i].en ? (VECS[i].pair ? 2'b10 : 2'b01) : 2'b00, VECS[i].valid, VECS[i].data);
         chk(hit == (VECS[i].exp ? (VECS[i].pair ? 2'b10 : 2'b01) : 2'b00),
             $sformatf("R5 R6 R7 R8 vector %0d", i), 32'(hit),
             32'(VECS[i].exp ? (VECS[i].pair ? 2 : 1) : 0));
      end
      // R5 flag lasts only while access repeats
      chk(hit == 2'b00, "R5 flag clears after access", 32'(hit), 32'h0);

      // R1 pattern readback
      wr(5'h0E, 32'h0BADF00D);
      wr(5'h1E, 32'h600DCAFE);
      rd(5'h0E, d, e);
      chk(d == 32'h0BADF00D && !e, "R1 pattern 0 readback", d, 32'h0BADF00D);
      rd(5'h1E, d, e);
      chk(d == 32'h600DCAFE && !e, "R1 pattern 1 readback", d, 32'h600DCAFE);

      // R2 mask reads fail
      wr(5'h0F, 32'h00FF00FF);
      rd(5'h0F, d, e);
      chk(d == '0 && e, "R2 mask 0 read", {d[30:0], e}, 32'h1);
      rd(5'h1F, d, e);
      chk(d == '0 && e, "R2 mask 1 read", {d[30:0], e}, 32'h1);
      // R4 strobe lasts one cycle
      @(negedge clk);
      chk(reg_err == 1'b0, "R4 err one cycle", 32'(reg_err), 32'h0);

      // R3 unmapped reads
      rd(5'h00, d, e);
      chk(d == '0 && e, "R3 index 0x00", {d[30:0], e}, 32'h1);
      rd(5'h1D, d, e);
      chk(d == '0 && e, "R3 index 0x1D", {d[30:0], e}, 32'h1);
      rd(5'h0E, d, e);
      chk(!e, "R4 good read after bad", 32'(e), 32'h0);

      // R9 independence
      wr(5'h0E, 32'h11112222);
      wr(5'h0F, 32'h0);
      wr(5'h1F, 32'h0);
      rd(5'h1E, d, e);
      chk(d == 32'h600DCAFE, "R9 pair 1 untouched", d, 32'h600DCAFE);
      access(2'b11, 1'b1, 32'h11112222);
      chk(hit == 2'b01, "R9 only pair 0 hits", 32'(hit), 32'h1);
      access(2'b11, 1'b1, 32'h600DCAFE);
      chk(hit == 2'b10, "R9 only pair 1 hits", 32'(hit), 32'h2);

      // R11 read and write same cycle
      reg_idx = 5'h0E; reg_wdata = 32'h33334444; reg_wr = 1'b1; reg_rd = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
      chk(reg_rdata == 32'h11112222, "R11 old value returned", reg_rdata, 32'h11112222);
      rd(5'h0E, d, e);
      chk(d == 32'h33334444, "R11 new value later", d, 32'h33334444);

      // R10 mid-run reset keeps contents
      trig_en = 2'b01; acc_valid = 1'b1; acc_data = 32'h33334444;
      @(negedge clk);
      chk(hit == 2'b01, "R10 hit before reset", 32'(hit), 32'h1);
      rst_n = 1'b0;
      #1;
      chk(hit == 2'b00 && reg_rdata == '0, "R10 async clear", 32'(hit), 32'h0);
      trig_en = '0; acc_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(5'h0E, d, e);
      chk(d == 32'h33334444, "R10 contents kept", d, 32'h33334444);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule